// File: doc/BRIEF.md
# Streamed Audio Sample PWM Player

This block turns a stream of 8-bit unsigned audio samples into a single-bit pulse-width modulated output for an amplified speaker. Bytes arrive from a serial receiver on a valid/ready stream and are queued in a circular buffer. At each PWM period boundary one sample is taken from the buffer, scaled to a duty value from 0 to 100, and that value sets the fraction of the next period during which the output is high.

A refill request tells the external sample source to send more bytes whenever the buffer has enough free room and playback is running. The host processor gates playback with a play enable and a pause input. A serial receiver cannot stall, so back-pressure is advisory only: `in_ready` is low exactly when the buffer is full, and a beat offered while `in_ready` is low is discarded and latches an overflow flag. Running dry at a period boundary holds the last duty value and latches an underrun flag. Both flags stay set until the host pulses their clear input.

Top module: `pwm_audio_player`

## Requirements
- R1: `in_ready` is high exactly when the buffer holds fewer than DEPTH (64) entries; every beat with `in_valid` and `in_ready` high is stored, and samples are played in arrival order.
- R2: A beat offered with `in_valid` high while `in_ready` is low is dropped and sets `overflow` on the next cycle; `overflow` stays high until a cycle with `clr_overflow` high and no new drop.
- R3: A sample s becomes duty value floor(s*100/256), except s = 255 which becomes 100.
- R4: While playing, a tick occurs every PRESC clocks, and a PWM period is 100 ticks; `pwm_out` is high while the period's tick count (0 to 99) is below the current duty value.
- R5: Duty 0 gives an output low for the entire period; duty 100 gives an output high for the entire period.
- R6: The duty value changes only at a period boundary (tick with count 99), and exactly one sample is taken from the buffer per boundary when the buffer is not empty.
- R7: At a boundary with an empty buffer the previous duty value is kept and `underrun` is set on the next cycle; it stays high until a cycle with `clr_underrun` high and no new underrun event.
- R8: `refill_req` is high when playback is running (`play_en` high, `pause` low) and the free space is at least REFILL_MIN (16) entries, and low otherwise.
- R9: When `play_en` is low or `pause` is high, no sample is read, the prescaler and period count hold, `refill_req` is low and `pwm_out` is low.
- R10: A synchronous `rst` empties the buffer, clears both flags, zeroes the duty value and counters, and forces `pwm_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample byte offered |
| in_data | input | 8 | Unsigned sample byte |
| in_ready | output | 1 | Buffer not full |
| play_en | input | 1 | Playback started |
| pause | input | 1 | Playback paused |
| clr_overflow | input | 1 | Clears the overflow flag |
| clr_underrun | input | 1 | Clears the underrun flag |
| refill_req | output | 1 | Request more samples from the source |
| pwm_out | output | 1 | Speaker PWM output |
| overflow | output | 1 | A beat was dropped while full |
| underrun | output | 1 | A boundary found the buffer empty |

## Verification
On every cycle the assertions check that the buffer occupancy never exceeds its depth, that a read never hits an empty buffer, that a drop while full leaves the occupancy at depth, that the duty value stays within 0 to 100 and moves only at a boundary, that the period count holds while stopped, and that an underrun event raises the flag. Only the bench's scenarios can show the arithmetic of the scaling, the number of high cycles per period for particular samples, arrival-order playback across pauses and resets, and the exact threshold at which the refill request turns on and off, all compared against a cycle model built from the requirements.

// File: rtl/pap_pkg.sv
package pap_pkg;
  localparam int SAMPLE_W = 8;
  localparam int PERIOD   = 100;
  localparam int DUTY_W   = 7;

  function automatic logic [DUTY_W-1:0] scale_sample(input logic [SAMPLE_W-1:0] s);
    logic [14:0] prod;
    prod = 15'(s) * 15'd100;
    if (s == {SAMPLE_W{1'b1}}) return DUTY_W'(PERIOD);
    return prod[14:8];
  endfunction
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic full, push, pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign wr_ready = !full;
  assign push     = wr_valid && !full;
  assign pop      = rd_en && !empty;
  assign rd_data  = mem[rp];
  assign level    = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  // R6
  read_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

  // R2
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full && !rd_en) |=> (cnt_q == CW'(DEPTH)));
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
  import pap_pkg::*;
#(
  parameter int PRESC = 4,
  localparam int PW   = (PRESC > 1) ? $clog2(PRESC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              avail,
  input  logic [DUTY_W-1:0] next_duty,
  output logic              pop,
  output logic              underrun_evt,
  output logic              pwm_o
);
  logic              tick, wrap;
  logic [DUTY_W-1:0] cnt_q, duty_q;

  generate
    if (PRESC == 1) begin : g_nopre
      assign tick = active;
    end else begin : g_pre
      logic [PW-1:0] pre_q;
      logic          pre_end;
      assign pre_end = (pre_q == PW'(PRESC - 1));
      assign tick    = active && pre_end;
      always_ff @(posedge clk) begin
        if (rst)         pre_q <= '0;
        else if (active) pre_q <= pre_end ? '0 : pre_q + 1'b1;
      end
    end
  endgenerate

  assign wrap         = tick && (cnt_q == DUTY_W'(PERIOD - 1));
  assign pop          = wrap && avail;
  assign underrun_evt = wrap && !avail;
  assign pwm_o        = active && (cnt_q < duty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (pop)  duty_q <= next_duty;
    end
  end

  // R5
  duty_range_chk: assert property (@(posedge clk) disable iff (rst)
    duty_q <= DUTY_W'(PERIOD));

  // R6
  duty_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(duty_q));

  // R9
  hold_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_audio_player.sv
module pwm_audio_player
  import pap_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int REFILL_MIN = 16,
  parameter int PRESC      = 4,
  localparam int CW        = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  input  logic                play_en,
  input  logic                pause,
  input  logic                clr_overflow,
  input  logic                clr_underrun,
  output logic                refill_req,
  output logic                pwm_out,
  output logic                overflow,
  output logic                underrun
);
  logic                active, pop, empty, uevt, drop;
  logic [SAMPLE_W-1:0] head;
  logic [CW-1:0]       level;
  logic [DUTY_W-1:0]   head_duty;

  assign active = play_en && !pause;

  sample_fifo #(.DW(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(in_valid), .wr_data(in_data), .wr_ready(in_ready),
    .rd_en(pop), .rd_data(head), .empty(empty), .level(level)
  );

  assign head_duty = scale_sample(head);

  pwm_engine #(.PRESC(PRESC)) u_pwm (
    .clk(clk), .rst(rst), .active(active), .avail(!empty),
    .next_duty(head_duty), .pop(pop), .underrun_evt(uevt), .pwm_o(pwm_out)
  );

  assign drop       = in_valid && !in_ready;
  assign refill_req = active && ((CW'(DEPTH) - level) >= CW'(REFILL_MIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (drop)              overflow <= 1'b1;
      else if (clr_overflow) overflow <= 1'b0;
      if (uevt)              underrun <= 1'b1;
      else if (clr_underrun) underrun <= 1'b0;
    end
  end

  // R7
  underrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
    uevt |=> underrun);
endmodule

// File: tb/tb_pwm_audio_player.sv
module tb_pwm_audio_player;
  localparam int DEPTH = 64;
  localparam int RMIN  = 16;
  localparam int PRESC = 2;

  logic clk = 0, rst = 1;
  logic in_valid = 0, play_en = 0, pause = 0, clr_overflow = 0, clr_underrun = 0;
  logic [7:0] in_data = 0;
  logic in_ready, refill_req, pwm_out, overflow, underrun;

  always #4 clk = ~clk;

  pwm_audio_player #(.DEPTH(DEPTH), .REFILL_MIN(RMIN), .PRESC(PRESC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .play_en(play_en), .pause(pause), .clr_overflow(clr_overflow), .clr_underrun(clr_underrun),
    .refill_req(refill_req), .pwm_out(pwm_out), .overflow(overflow), .underrun(underrun)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [7:0] mq[$];
  int m_pre = 0, m_cnt = 0, m_duty = 0;
  bit m_ovf = 0, m_unf = 0;

  function automatic int exp_duty(input int s);
    if (s == 255) return 100;
    return (s * 100) / 256;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_pre = 0; m_cnt = 0; m_duty = 0; m_ovf = 0; m_unf = 0;
    end else begin
      bit act, tk, wr, full_pre, av;
      act = play_en && !pause;
      full_pre = (mq.size() == DEPTH);
      av = (mq.size() > 0);
      tk = act && (m_pre == PRESC - 1);
      wr = tk && (m_cnt == 99);
      if (act) m_pre = tk ? 0 : m_pre + 1;
      if (tk) m_cnt = wr ? 0 : m_cnt + 1;
      if (wr && av) m_duty = exp_duty(int'(mq.pop_front()));
      if (wr && !av) m_unf = 1; else if (clr_underrun) m_unf = 0;
      if (in_valid && full_pre) m_ovf = 1; else if (clr_overflow) m_ovf = 0;
      if (in_valid && !full_pre) mq.push_back(in_data);
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    bit act;
    @(negedge clk);
    act = play_en && !pause;
    chk("R4 pwm_out", pwm_out, rst ? 1'b0 : (act && (m_cnt < m_duty)));
    chk("R1 in_ready", in_ready, rst ? 1'b1 : (mq.size() < DEPTH));
    chk("R8 refill_req", refill_req, act && ((DEPTH - (rst ? 0 : mq.size())) >= RMIN));
    chk("R2 overflow", overflow, m_ovf);
    chk("R7 underrun", underrun, m_unf);
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0;
    repeat (3) step();
    rst = 0;
    step();
  endtask

  task automatic push(input logic [7:0] v);
    in_valid = 1; in_data = v;
    step();
    in_valid = 0;
  endtask

  task automatic measure(input int expd, input string tag);
    int highs = 0, guard = 0;
    while (!(m_cnt == 0 && m_pre == 0 && m_duty == expd) && guard < 1000) begin
      step(); guard++;
    end
    for (int i = 0; i < 100 * PRESC; i++) begin
      if (pwm_out) highs++;
      step();
    end
    n_cmp++;
    if (highs != expd * PRESC) begin
      n_bad++;
      $display("FAIL %s high cycles: actual %0d expected %0d", tag, highs, expd * PRESC);
    end
  endtask

  initial begin
    void'($urandom(32'd20240917));
    do_reset();
    // R10 reset state
    chk("R10 pwm", pwm_out, 1'b0);
    chk("R10 ready", in_ready, 1'b1);
    chk("R10 ovf", overflow, 1'b0);
    chk("R10 unf", underrun, 1'b0);

    push(8'd255); push(8'd0); push(8'd128); push(8'd1);
    play_en = 1;
    step();
    chk("R8 refill while playing", refill_req, 1'b1);
    measure(100, "R5 full duty");
    measure(0, "R5 zero duty");
    measure(50, "R3 sample 128");
    measure(0, "R3 sample 1");
    repeat (250) step();
    chk("R7 underrun latched", underrun, 1'b1);

    // R9 pause
    pause = 1;
    push(8'd200); push(8'd100);
    repeat (300) step();
    chk("R9 pwm low paused", pwm_out, 1'b0);
    chk("R9 no refill paused", refill_req, 1'b0);
    pause = 0;
    measure(78, "R9 resumed in order");
    measure(39, "R1 arrival order");

    // R2 overflow
    pause = 1;
    for (int i = 0; i < 70; i++) push(8'(i * 3));
    chk("R1 ready low when full", in_ready, 1'b0);
    chk("R2 overflow set", overflow, 1'b1);
    clr_overflow = 1; step(); clr_overflow = 0; step();
    chk("R2 overflow cleared", overflow, 1'b0);

    // R6 one sample per boundary
    do_reset();
    push(8'd200); push(8'd50);
    play_en = 1; pause = 0;
    measure(78, "R6 first");
    measure(19, "R6 next boundary");
    chk("R10 after reset ovf", overflow, 1'b0);

    // random phase
    begin
      int rate = 40;
      for (int i = 0; i < 20000; i++) begin
        if (i % 2000 == 0) begin
          case ((i / 2000) % 3)
            0: rate = 5;
            1: rate = 40;
            default: rate = 95;
          endcase
        end
        in_valid = (($urandom % 100) < rate);
        in_data = 8'($urandom);
        if ($urandom % 400 == 0) play_en = ~play_en;
        if ($urandom % 300 == 0) pause = ~pause;
        clr_overflow = ($urandom % 100 == 0);
        clr_underrun = ($urandom % 100 == 0);
        rst = ($urandom % 3000 == 0);
        step();
      end
      rst = 0; in_valid = 0; clr_overflow = 0; clr_underrun = 0;
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule